// File: doc/BRIEF.md
# Serial EEPROM Block Read Engine

This block is a hardware sequencer that fetches a run of bytes from a serial EEPROM over SPI. It is always the bus master. It drives the serial clock, the outgoing data line and one of several active-low chip-select lines, and it samples the incoming data line. A client sets up a start address and a byte count, then pulses a go strobe. The engine opens the chip select and sends the read opcode. It follows that with 2 or 3 address bytes and then clocks in the requested number of data bytes. Each data byte comes out on a one-cycle valid strobe. The engine reports completion with a one-cycle done pulse and a status code.

The settings are sampled when go is accepted:
- clock prescale
- SPI mode (clock polarity and phase)
- address width (16 or 24 bits)
- which chip-select line to use
- a setup delay between chip-select assertion and the first clock edge

A per-byte watchdog limits how long any single byte slot may take. When it expires, the engine stops the shifter and releases the chip select.

The control is a four-state machine:
- `ST_IDLE` waits for go. It answers zero-length and bad-width requests directly.
- `ST_FLUSH` clears the receive holding register and asserts the chip select.
- `ST_SETUP` counts out the chip-select setup delay.
- `ST_XFER` shifts the header bytes and then the data bytes.

The transitions are:
- accept (`ST_IDLE`→`ST_FLUSH`)
- open (`ST_FLUSH`→`ST_SETUP`)
- launch (`ST_SETUP`→`ST_XFER`)
- finish (`ST_XFER`→`ST_IDLE`, after the last data byte)
- abort (`ST_SETUP` or `ST_XFER`→`ST_IDLE`, when the watchdog expires)

Top module: `spi_eeprom_reader`

## Requirements
- R1: Only `cfg_addr_bits` values 16 and 24 are accepted. For a nonzero-length request with any other value, the cycle after go shows `done`=1 with `status`=1, and no chip select is ever asserted.
- R2: Each transaction starts with the opcode byte 0x03. The address follows, most significant byte first: 3 bytes for 24-bit mode and 2 bytes (address bits 15..0) for 16-bit mode.
- R3: Every byte is 8 bits, shifted most significant bit first in both directions. Data byte k carries the memory content at address start+k.
- R4: While data bytes are being read, every bit the engine drives on `spi_mosi` is 0.
- R5: Exactly one chip-select line, bit `cfg_cs_sel` of `spi_cs_n`, goes low. It stays low without a break from before the first header bit until the last data byte completes. It returns high in the cycle that `done` pulses.
- R6: A request with `req_len`=0 shows `done`=1 and `status`=0 in the cycle after go. It never asserts a chip select or `busy`.
- R7: Each half period of the serial clock lasts max(`cfg_prescale`-1,0)+1 base clocks, so prescale values 0 and 1 both run at the fastest rate.
- R8: The first serial clock edge comes `cfg_cs_delay`+max(`cfg_prescale`-1,0)+2 base clocks after the chip select goes low.
- R9: Each byte slot has a limit of (`cfg_prescale`+1)×160 base clocks. The first slot includes the setup delay. On expiry the engine stops shifting, raises the chip select, pulses `done` with `status`=2, and produces no further `rd_valid`.
- R10: When a transaction starts, `rd_data` is cleared to 0x00. It holds that value until the first new data byte arrives.
- R11: `busy` is high from the cycle after an accepted go until the `done` cycle. A go strobe while busy is ignored, and only one `done` results.
- R12: `cfg_mode` bit 1 is clock polarity: the clock idles at that level. `cfg_mode` bit 0 is clock phase: 0 samples on the leading edge, 1 samples on the trailing edge. All four modes read correct data.
- R13: Each data byte is shown with a one-cycle `rd_valid`. The final byte's `rd_valid` falls in the same cycle as the successful `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | DIV_W | Clock divide setting |
| cfg_mode | input | 2 | Bit 1 clock polarity, bit 0 clock phase |
| cfg_addr_bits | input | 5 | Address width in bits (16 or 24) |
| cfg_cs_sel | input | CS_W | Chip-select line index |
| cfg_cs_delay | input | DLY_W | Setup delay in base clocks |
| req_go | input | 1 | Start strobe |
| req_addr | input | 24 | Start address |
| req_len | input | LEN_W | Number of data bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 bad width, 2 timeout |
| rd_valid | output | 1 | Data byte strobe |
| rd_data | output | 8 | Received data byte |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Two functions can land in the same cycle: completion of the final data byte and the successful end of the transaction. The last `rd_valid`, the `done` pulse and the release of the chip select must all appear together. Every read ends in that cycle, so the bench samples it directly and requires `rd_valid`, `done`, status 0 and an all-high chip-select vector at once. A second overlap is a go strobe that arrives while a read is in flight. The bench provokes it mid-transfer with a zero-length, bad-width request and judges it by counting exactly one `done` and a scoreboard that still matches.

// File: rtl/ser_rd_pkg.sv
`timescale 1ns/1ps
package ser_rd_pkg;
    localparam int CHAR_BITS = 8;
    localparam int ADDR_W    = 24;
    localparam int EDGE_LAST = 2 * CHAR_BITS - 1;
    localparam logic [7:0] READ_OPCODE = 8'h03;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_SETUP,
        ST_XFER
    } rd_state_e;

    typedef enum logic [1:0] {
        RS_OK        = 2'd0,
        RS_BAD_WIDTH = 2'd1,
        RS_TIMEOUT   = 2'd2
    } rd_status_e;
endpackage

// File: rtl/ser_rd_shifter.sv
`timescale 1ns/1ps
module ser_rd_shifter
    import ser_rd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 abort,
    input  logic [CHAR_BITS-1:0] tx_byte,
    input  logic [DIV_W-1:0]     half_div,
    input  logic                 cpol,
    input  logic                 cpha,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 mosi,
    output logic [CHAR_BITS-1:0] rx_byte,
    output logic                 byte_done
);
    localparam int EW = $clog2(2 * CHAR_BITS);

    logic                 running;
    logic                 lvl;
    logic [DIV_W-1:0]     hcnt;
    logic [EW-1:0]        eidx;
    logic [CHAR_BITS-1:0] sh_tx;
    logic [CHAR_BITS-1:0] sh_rx;
    logic                 edge_now;
    logic                 leading;

    assign edge_now = running && (hcnt == half_div);
    assign leading  = ~eidx[0];
    assign sclk     = cpol ^ lvl;
    assign mosi     = sh_tx[CHAR_BITS-1];
    assign rx_byte  = sh_rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running   <= 1'b0;
            lvl       <= 1'b0;
            hcnt      <= '0;
            eidx      <= '0;
            sh_tx     <= '0;
            sh_rx     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (abort) begin
                running <= 1'b0;
                lvl     <= 1'b0;
            end else if (start) begin
                running <= 1'b1;
                lvl     <= 1'b0;
                hcnt    <= '0;
                eidx    <= '0;
                sh_tx   <= tx_byte;
                sh_rx   <= '0;
            end else if (running) begin
                if (edge_now) begin
                    hcnt <= '0;
                    lvl  <= ~lvl;
                    eidx <= eidx + 1'b1;
                    if (leading) begin
                        if (!cpha)
                            sh_rx <= {sh_rx[CHAR_BITS-2:0], miso};
                        else if (eidx != '0)
                            sh_tx <= {sh_tx[CHAR_BITS-2:0], 1'b0};
                    end else begin
                        if (cpha)
                            sh_rx <= {sh_rx[CHAR_BITS-2:0], miso};
                        else if (eidx != EW'(EDGE_LAST))
                            sh_tx <= {sh_tx[CHAR_BITS-2:0], 1'b0};
                    end
                    if (eidx == EW'(EDGE_LAST)) begin
                        running   <= 1'b0;
                        byte_done <= 1'b1;
                    end
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (sclk == cpol)); // R12
    AST_BYTE_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(running)); // R3
    AST_BYTE_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done); // R13
endmodule

// File: rtl/ser_rd_watchdog.sv
`timescale 1ns/1ps
module ser_rd_watchdog
    import ser_rd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int MULT  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic [DIV_W-1:0] prescale,
    output logic             expired
);
    localparam int UNIT  = CHAR_BITS * MULT;
    localparam int CNT_W = DIV_W + 1 + $clog2(UNIT);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit   = (CNT_W'(prescale) + CNT_W'(1)) * CNT_W'(UNIT);
    assign expired = enable && (cnt >= limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (enable)
            cnt <= cnt + 1'b1;
    end

    AST_WD_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !clear) |-> (cnt < limit)); // R9
endmodule

// File: rtl/spi_eeprom_reader.sv
`timescale 1ns/1ps
module spi_eeprom_reader
    import ser_rd_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int DIV_W   = 8,
    parameter int DLY_W   = 8,
    parameter int LEN_W   = 16,
    parameter int WD_MULT = 20,
    parameter int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     cfg_prescale,
    input  logic [1:0]           cfg_mode,
    input  logic [4:0]           cfg_addr_bits,
    input  logic [CS_W-1:0]      cfg_cs_sel,
    input  logic [DLY_W-1:0]     cfg_cs_delay,
    input  logic                 req_go,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           status,
    output logic                 rd_valid,
    output logic [7:0]           rd_data,
    output logic                 spi_sclk,
    output logic                 spi_mosi,
    input  logic                 spi_miso,
    output logic [NUM_CS-1:0]    spi_cs_n
);
    localparam int HDR_W = CHAR_BITS + ADDR_W;

    rd_state_e          state, nxt;
    rd_status_e         st_q;
    logic [DIV_W-1:0]   lat_pre;
    logic               lat_cpol, lat_cpha, lat_wide;
    logic [CS_W-1:0]    lat_sel;
    logic [DLY_W-1:0]   lat_dly, dcnt;
    logic [ADDR_W-1:0]  lat_addr;
    logic [LEN_W-1:0]   remain;
    logic [2:0]         sent;
    logic               cur_is_data;

    logic               width_ok, go_ok;
    logic [2:0]         hdr_n;
    logic [HDR_W-1:0]   hdr_word;
    logic [7:0]         hdr_byte, tx_next;
    logic [DIV_W-1:0]   half_div;
    logic               shift_start, byte_done, wd_exp, wd_clear, wd_en;
    logic               abort_now, last_byte, finish_ok;
    logic [7:0]         rx_byte;
    logic [NUM_CS-1:0]  cs_on;

    assign status   = st_q;
    assign width_ok = (cfg_addr_bits == 5'd16) || (cfg_addr_bits == 5'd24);
    assign go_ok    = req_go && (req_len != '0) && width_ok;
    assign hdr_n    = lat_wide ? 3'd4 : 3'd3;
    assign hdr_word = lat_wide ? {READ_OPCODE, lat_addr}
                               : {READ_OPCODE, lat_addr[15:0], 8'h00};
    assign half_div = (lat_pre == '0) ? '0 : lat_pre - 1'b1;
    assign cs_on    = NUM_CS'(1) << lat_sel;

    always_comb begin
        unique case (sent)
            3'd0:    hdr_byte = hdr_word[HDR_W-1 -: 8];
            3'd1:    hdr_byte = hdr_word[HDR_W-9 -: 8];
            3'd2:    hdr_byte = hdr_word[HDR_W-17 -: 8];
            default: hdr_byte = hdr_word[7:0];
        endcase
    end
    assign tx_next = (sent < hdr_n) ? hdr_byte : 8'h00;

    assign last_byte   = cur_is_data && (remain == LEN_W'(1));
    assign abort_now   = wd_exp && ((state == ST_SETUP) ||
                                    (state == ST_XFER && !byte_done));
    assign shift_start = (state == ST_SETUP && dcnt == lat_dly && !wd_exp) ||
                         (state == ST_XFER && byte_done && !last_byte);
    assign finish_ok   = (state == ST_XFER) && byte_done && last_byte;
    assign wd_clear    = (state == ST_FLUSH) || (state == ST_XFER && shift_start);
    assign wd_en       = (state == ST_SETUP) || (state == ST_XFER);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = go_ok ? ST_FLUSH : ST_IDLE;
            ST_FLUSH: nxt = ST_SETUP;
            ST_SETUP: begin
                if (abort_now)        nxt = ST_IDLE;
                else if (shift_start) nxt = ST_XFER;
            end
            ST_XFER:  if (abort_now || finish_ok) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            done        <= 1'b0;
            st_q        <= RS_OK;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            spi_cs_n    <= '1;
            lat_pre     <= '0;
            lat_cpol    <= 1'b0;
            lat_cpha    <= 1'b0;
            lat_wide    <= 1'b0;
            lat_sel     <= '0;
            lat_dly     <= '0;
            lat_addr    <= '0;
            remain      <= '0;
            dcnt        <= '0;
            sent        <= '0;
            cur_is_data <= 1'b0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            if (state == ST_IDLE && req_go) begin
                if (req_len == '0) begin
                    done <= 1'b1;
                    st_q <= RS_OK;
                end else if (!width_ok) begin
                    done <= 1'b1;
                    st_q <= RS_BAD_WIDTH;
                end else begin
                    busy     <= 1'b1;
                    lat_pre  <= cfg_prescale;
                    lat_cpol <= cfg_mode[1];
                    lat_cpha <= cfg_mode[0];
                    lat_wide <= (cfg_addr_bits == 5'd24);
                    lat_sel  <= cfg_cs_sel;
                    lat_dly  <= cfg_cs_delay;
                    lat_addr <= req_addr;
                    remain   <= req_len;
                end
            end
            if (state == ST_FLUSH) begin
                rd_data     <= '0;
                spi_cs_n    <= ~cs_on;
                dcnt        <= '0;
                sent        <= '0;
                cur_is_data <= 1'b0;
            end
            if (state == ST_SETUP && dcnt != lat_dly)
                dcnt <= dcnt + 1'b1;
            if (shift_start) begin
                cur_is_data <= (sent == hdr_n);
                if (sent != hdr_n) sent <= sent + 1'b1;
            end
            if (state == ST_XFER && byte_done && cur_is_data) begin
                rd_valid <= 1'b1;
                rd_data  <= rx_byte;
                remain   <= remain - 1'b1;
            end
            if (finish_ok) begin
                done     <= 1'b1;
                st_q     <= RS_OK;
                busy     <= 1'b0;
                spi_cs_n <= '1;
            end
            if (abort_now) begin
                done     <= 1'b1;
                st_q     <= RS_TIMEOUT;
                busy     <= 1'b0;
                spi_cs_n <= '1;
            end
        end
    end

    ser_rd_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (shift_start),
        .abort     (abort_now),
        .tx_byte   (tx_next),
        .half_div  (half_div),
        .cpol      (lat_cpol),
        .cpha      (lat_cpha),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .rx_byte   (rx_byte),
        .byte_done (byte_done)
    );

    ser_rd_watchdog #(.DIV_W(DIV_W), .MULT(WD_MULT)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (wd_clear),
        .enable   (wd_en),
        .prescale (lat_pre),
        .expired  (wd_exp)
    );

    AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n)); // R5
    AST_CS_HELD_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) |-> $stable(spi_cs_n)); // R5
    AST_VALID_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(spi_cs_n) != '1)); // R13
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11
    AST_ZERO_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_go && req_len == '0)
        |=> (done && status == 2'd0 && spi_cs_n == '1 && !busy)); // R6
    AST_BAD_WIDTH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_go && req_len != '0 && !width_ok)
        |=> (done && status == 2'd1 && spi_cs_n == '1)); // R1
endmodule

// File: tb/sim_spi_eeprom_reader.sv
`timescale 1ns/1ps
module sim_spi_eeprom_reader;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_prescale = '0;
    logic [1:0]  cfg_mode = '0;
    logic [4:0]  cfg_addr_bits = 5'd24;
    logic [1:0]  cfg_cs_sel = '0;
    logic [7:0]  cfg_cs_delay = '0;
    logic        req_go = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        busy, done, rd_valid, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [1:0]  status;
    logic [7:0]  rd_data;
    logic [NCS-1:0] spi_cs_n;

    int n_chk = 0, n_fail = 0, done_cnt = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_eeprom_reader #(.NUM_CS(NCS)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_mode(cfg_mode),
        .cfg_addr_bits(cfg_addr_bits), .cfg_cs_sel(cfg_cs_sel), .cfg_cs_delay(cfg_cs_delay),
        .req_go(req_go), .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
        .status(status), .rd_valid(rd_valid), .rd_data(rd_data), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return (a[7:0] ^ 8'h5A) + a[15:8] + {a[20:16], a[23:21]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // behavioural EEPROM
    logic        m_cpol = 0, m_cpha = 0, m_wide = 1;
    int          m_hdr_bits = 32, m_n = 0, m_edges = 0, m_acts = 0;
    logic [31:0] m_hdr = '0;
    logic [NCS-1:0] m_cs_seen = '0;
    bit          m_mosi_bad = 0;
    time         t_cs = 0, t_e1 = 0, t_e2 = 0;
    wire         cs_any = (spi_cs_n != '1);

    always @(cs_any) begin
        if (cs_any) begin
            m_n = 0; m_hdr = '0; m_mosi_bad = 0; m_edges = 0;
            t_cs = $time; m_cs_seen = ~spi_cs_n; m_acts++; spi_miso = 1'b0;
        end
    end

    always @(spi_sclk) begin
        if (cs_any) begin
            logic lead;
            m_edges++;
            if (m_edges == 1) t_e1 = $time;
            if (m_edges == 2) t_e2 = $time;
            lead = (spi_sclk != m_cpol);
            if (lead != m_cpha) begin
                if (m_n < m_hdr_bits) m_hdr = {m_hdr[30:0], spi_mosi};
                else if (spi_mosi) m_mosi_bad = 1;
                m_n++;
            end else if (m_n >= m_hdr_bits) begin
                int k, b;
                logic [23:0] a;
                k = (m_n - m_hdr_bits) / 8;
                b = (m_n - m_hdr_bits) % 8;
                if (m_wide) a = m_hdr[23:0] + 24'(k);
                else        a = {8'h00, m_hdr[15:0] + 16'(k)};
                spi_miso = mem_byte(a)[7-b];
            end else begin
                spi_miso = 1'b0;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) done_cnt++;
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk(0, "R9/R13 unexpected rd_valid", {24'h0, rd_data}, 32'h0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R3/R12 data byte", {24'h0, rd_data}, {24'h0, e});
            end
        end
    end

    task automatic run_read(input logic [23:0] addr, input int len, input int pre,
                            input int mode, input int width, input int sel,
                            input int dly, input int exp_st);
        int eff, acts0, guard;
        logic [31:0] hexp;
        eff = (pre > 0) ? pre - 1 : 0;
        cfg_prescale = 8'(pre); cfg_mode = 2'(mode); cfg_addr_bits = 5'(width);
        cfg_cs_sel = 2'(sel); cfg_cs_delay = 8'(dly); req_addr = addr; req_len = 16'(len);
        m_cpol = mode[1]; m_cpha = mode[0]; m_wide = (width == 24);
        m_hdr_bits = m_wide ? 32 : 24;
        if (exp_st == 0)
            for (int k = 0; k < len; k++)
                exp_q.push_back(m_wide ? mem_byte(addr + 24'(k))
                                       : mem_byte({8'h00, addr[15:0] + 16'(k)}));
        acts0 = m_acts;
        @(negedge clk) req_go = 1'b1;
        @(negedge clk) req_go = 1'b0;
        if (len == 0 || exp_st == 1) begin
            chk(done == 1'b1, "R1/R6 done next cycle", {31'h0, done}, 32'h1);
            chk(status == 2'(exp_st), "R1/R6 status", {30'h0, status}, exp_st);
            repeat (4) @(negedge clk);
            chk(m_acts == acts0 && !busy, "R1/R6 no chip select", m_acts, acts0);
            return;
        end
        repeat (2) @(negedge clk);
        chk(rd_data == 8'h00, "R10 rd_data flushed", {24'h0, rd_data}, 32'h0);
        chk(busy == 1'b1, "R11 busy during read", {31'h0, busy}, 32'h1);
        guard = 0;
        while (!done && guard < 40000) begin @(negedge clk); guard++; end
        chk(status == 2'(exp_st), "R9/R11 final status", {30'h0, status}, exp_st);
        chk(spi_cs_n == '1, "R5/R9 chip select released at done", spi_cs_n, 32'hF);
        chk(spi_sclk == m_cpol, "R12 clock idle level", spi_sclk, m_cpol);
        if (exp_st == 0) begin
            chk(rd_valid == 1'b1, "R13 last byte with done", {31'h0, rd_valid}, 32'h1);
            hexp = m_wide ? {8'h03, addr} : {8'h00, 8'h03, addr[15:0]};
            chk(m_hdr == hexp, "R2 header bytes", m_hdr, hexp);
            chk(!m_mosi_bad, "R4 zero mosi in data phase", m_mosi_bad, 0);
            chk(m_cs_seen == NCS'(1) << sel, "R5 selected line", m_cs_seen, NCS'(1) << sel);
            chk((t_e1 - t_cs) == time'((dly + eff + 2) * CLK_PERIOD), "R8 setup delay",
                32'(t_e1 - t_cs), (dly + eff + 2) * CLK_PERIOD);
            chk((t_e2 - t_e1) == time'((eff + 1) * CLK_PERIOD), "R7 half period",
                32'(t_e2 - t_e1), (eff + 1) * CLK_PERIOD);
        end else begin
            chk(m_edges == 0, "R9 no clock after abort", m_edges, 0);
        end
        @(negedge clk);
        chk(exp_q.size() == 0, "R13 scoreboard drained", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == '1 && !busy && !done && !rd_valid, "R5/R11 reset state",
            {busy, done, rd_valid, spi_cs_n}, 32'hF);
        chk(spi_sclk == 1'b0, "R12 reset clock level", spi_sclk, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_read(24'h123456, 5, 0, 0, 24, 0, 0, 0);      // R7 prescale 0
        run_read(24'h7FABCD, 4, 1, 3, 16, 2, 3, 0);      // R7 prescale 1 same rate
        run_read(24'h00F00D, 3, 4, 1, 24, 1, 5, 0);
        run_read(24'h00FFFE, 4, 2, 2, 16, 3, 1, 0);
        run_read(24'h000100, 0, 0, 0, 24, 0, 0, 0);      // R6
        run_read(24'h000100, 2, 0, 0, 8, 0, 0, 1);       // R1
        run_read(24'h000100, 2, 0, 0, 20, 0, 0, 1);      // R1
        run_read(24'h000100, 4, 0, 0, 24, 0, 200, 2);    // R9 timeout in setup
        d0 = done_cnt;
        fork
            run_read(24'hA5A5A5, 3, 3, 0, 24, 1, 2, 0);
            begin
                repeat (30) @(negedge clk);
                req_go = 1'b1; req_len = 16'd0; cfg_addr_bits = 5'd8;
                @(negedge clk) req_go = 1'b0;
            end
        join
        chk(done_cnt - d0 == 1, "R11 go while busy ignored", done_cnt - d0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule